// File: doc/BRIEF.md
# GCI Highway Subframe Transceiver

This block is a slave port on a four-wire time-division highway. The port runs on the highway clock. It locks to the rising edge of an 8 kHz frame sync and counts bit periods across the 125 µs frame. The frame is split into eight subframes of 32 bits each. In its own subframe the port sends one 32-bit word: two voice bytes, a monitor byte and a signaling byte. In the same bits it captures the matching received word. The signaling byte holds six command/indicate bits above two monitor handshake bits.

Three strap inputs fix the port's configuration, and the port samples them once, on the first clock edge after reset is released. The first strap enables or disables the port. The second selects one or two highway clocks per bit. The third picks the subframe, and it is inverted, so all-ones selects subframe 0. The transmit word is loaded from parallel inputs when the subframe starts. The received word is presented on parallel outputs together with a one-cycle valid strobe.

Top module: `gci_slot_port`

## Requirements
- R1: While reset is asserted, and after reset until the first frame sync edge, dtx_oe_o is 0, dtx_o is 1, rx_valid_o is 0 and every received-byte output is 0.
- R2: The straps are sampled on the first rising clock edge after rst_ni goes high. Later changes on the strap inputs have no effect until the next reset.
- R3: When strap_mode_i is sampled as 1, the port is disabled. It never raises dtx_oe_o and never raises rx_valid_o, whatever happens on fsync_i and drx_i.
- R4: The own subframe index is the bitwise NOT of strap_sel_i. Subframe s covers bit periods 32*s to 32*s+31. Bit period 0 starts in the clock cycle after the clock edge that first samples fsync_i high following a low.
- R5: During its own subframe the port holds dtx_oe_o at 1 and sends {B1, B2, M, SC} most significant bit first. SC is {tx_ci_i[5:0], tx_hs_i[1:0]}. The word is taken from the transmit inputs at the clock edge that starts the subframe.
- R6: Outside its own subframe, dtx_oe_o is 0 and dtx_o is 1.
- R7: The bits on drx_i in the own subframe are assembled with the same packing as R5. They appear on the rx outputs with rx_valid_o high for exactly one cycle, which is the first cycle after the subframe's last bit period.
- R8: When strap_rate_i is sampled as 1, each bit period lasts two clocks. dtx_o holds steady across both clocks, and drx_i is sampled only at the edge that ends the second clock.
- R9: A frame sync edge that arrives before 256 bit periods have passed restarts the count at bit 0. A subframe cut short this way produces no valid strobe, and the next full frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Highway clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_mode_i | input | 1 | Enable strap: 0 enables the port, 1 disables it |
| strap_rate_i | input | 1 | Rate strap: 0 gives one clock per bit, 1 gives two |
| strap_sel_i | input | 3 | Inverted subframe select strap |
| fsync_i | input | 1 | Frame sync; the rising edge starts a frame |
| drx_i | input | 1 | Serial receive data |
| dtx_o | output | 1 | Serial transmit data, 1 when idle |
| dtx_oe_o | output | 1 | Transmit output enable |
| tx_b1_i | input | 8 | First voice byte to send |
| tx_b2_i | input | 8 | Second voice byte to send |
| tx_mon_i | input | 8 | Monitor byte to send |
| tx_ci_i | input | 6 | Command bits to send |
| tx_hs_i | input | 2 | Monitor handshake bits to send |
| rx_b1_o | output | 8 | First voice byte received |
| rx_b2_o | output | 8 | Second voice byte received |
| rx_mon_o | output | 8 | Monitor byte received |
| rx_ci_o | output | 6 | Indicate bits received |
| rx_hs_o | output | 2 | Monitor handshake bits received |
| rx_valid_o | output | 1 | One-cycle strobe for a new received word |

## Verification
The hardest case to reach from the ports is the two-clock bit period, where only the second clock of each bit may sample drx_i. A port that samples on the first clock gives the same result as long as the line is steady. To catch it, the bench drives the inverted bit value during the first clock of every bit period and the true value during the second. Two further cases need straps or frame sync to move in unusual ways. For strap retention, the bench changes the select pins after reset and then checks the subframe timing. For a cut-short subframe, the bench raises frame sync a second time partway through the port's own subframe.

// File: rtl/gci_pkg.sv
package gci_pkg;
  typedef enum logic {
    RATE_1X = 1'b0,
    RATE_2X = 1'b1
  } rate_e;

  // one subframe word, MSB first on the line
  typedef struct packed {
    logic [7:0] b1;
    logic [7:0] b2;
    logic [7:0] mon;
    logic [5:0] ci;
    logic [1:0] hs;
  } sub_word_t;
endpackage

// File: rtl/gci_strap_latch.sv
module gci_strap_latch
  import gci_pkg::*;
#(
  parameter int unsigned SLOT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              rate_i,
  input  logic [SLOT_W-1:0] sel_i,
  output logic              armed_o,
  output logic              en_o,
  output rate_e             rate_o,
  output logic [SLOT_W-1:0] slot_o
);
  // capture once on the first edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      en_o    <= 1'b0;
      rate_o  <= RATE_1X;
      slot_o  <= '0;
    end else if (!armed_o) begin
      armed_o <= 1'b1;
      en_o    <= ~mode_i;
      rate_o  <= rate_e'(rate_i);
      slot_o  <= ~sel_i;
    end
  end
endmodule

// File: rtl/gci_frame_timer.sv
module gci_frame_timer
  import gci_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned CNT_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             armed_i,
  input  logic             en_i,
  input  rate_e            rate_i,
  input  logic             fsync_i,
  output logic             frame_start_o,
  output logic             bit_end_o,
  output logic             synced_o,
  output logic [CNT_W-1:0] bit_o
);
  logic fsync_q;
  logic phase_q;

  assign frame_start_o = armed_i && en_i && fsync_i && !fsync_q;
  assign bit_end_o     = (rate_i == RATE_1X) || phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsync_q  <= 1'b0;
      phase_q  <= 1'b0;
      synced_o <= 1'b0;
      bit_o    <= '0;
    end else begin
      fsync_q <= fsync_i;
      if (frame_start_o) begin
        bit_o    <= '0;
        phase_q  <= 1'b0;
        synced_o <= 1'b1;
      end else if (synced_o) begin
        if (bit_end_o) begin
          phase_q <= 1'b0;
          bit_o   <= (bit_o == CNT_W'(FRAME_BITS - 1)) ? '0 : bit_o + 1'b1;
        end else begin
          phase_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gci_slot_shifter.sv
module gci_slot_shifter #(
  parameter int unsigned SLOT_W     = 3,
  parameter int unsigned SUB_BITS   = 32,
  parameter int unsigned POS_W      = 5,
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned CNT_W      = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                synced_i,
  input  logic                frame_start_i,
  input  logic                bit_end_i,
  input  logic [CNT_W-1:0]    bit_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic [SUB_BITS-1:0] tx_word_i,
  input  logic                drx_i,
  output logic                dtx_o,
  output logic                oe_o,
  output logic [SUB_BITS-1:0] rx_word_o,
  output logic                rx_valid_o
);
  logic [SUB_BITS-1:0] tx_sh_q;
  logic [SUB_BITS-1:0] rx_sh_q;
  logic [CNT_W-1:0]    bit_next;
  logic [CNT_W-1:0]    slot_base;
  logic                in_slot;
  logic                last_bit;
  logic                load;
  logic                step;

  assign bit_next  = (bit_i == CNT_W'(FRAME_BITS - 1)) ? '0 : bit_i + 1'b1;
  assign slot_base = CNT_W'(slot_i) << POS_W;
  assign in_slot   = synced_i && ((bit_i >> POS_W) == CNT_W'(slot_i));
  assign last_bit  = (bit_i[POS_W-1:0] == '1);
  assign load      = frame_start_i ? (slot_i == '0)
                                   : (synced_i && bit_end_i && (bit_next == slot_base));
  // a sync edge preempts any shift or capture in the current bit
  assign step      = in_slot && bit_end_i && !frame_start_i;

  assign oe_o  = in_slot;
  assign dtx_o = in_slot ? tx_sh_q[SUB_BITS-1] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh_q    <= '0;
      rx_sh_q    <= '0;
      rx_word_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (load)      tx_sh_q <= tx_word_i;
      else if (step) tx_sh_q <= tx_sh_q << 1;
      if (step) begin
        rx_sh_q <= {rx_sh_q[SUB_BITS-2:0], drx_i};
        if (last_bit) begin
          rx_word_o  <= {rx_sh_q[SUB_BITS-2:0], drx_i};
          rx_valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gci_slot_port.sv
module gci_slot_port
  import gci_pkg::*;
#(
  parameter int unsigned NUM_SUB = 8,
  localparam int unsigned SLOT_W = $clog2(NUM_SUB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_mode_i,
  input  logic              strap_rate_i,
  input  logic [SLOT_W-1:0] strap_sel_i,
  input  logic              fsync_i,
  input  logic              drx_i,
  output logic              dtx_o,
  output logic              dtx_oe_o,
  input  logic [7:0]        tx_b1_i,
  input  logic [7:0]        tx_b2_i,
  input  logic [7:0]        tx_mon_i,
  input  logic [5:0]        tx_ci_i,
  input  logic [1:0]        tx_hs_i,
  output logic [7:0]        rx_b1_o,
  output logic [7:0]        rx_b2_o,
  output logic [7:0]        rx_mon_o,
  output logic [5:0]        rx_ci_o,
  output logic [1:0]        rx_hs_o,
  output logic              rx_valid_o
);
  localparam int unsigned SUB_BITS   = $bits(sub_word_t);
  localparam int unsigned POS_W      = $clog2(SUB_BITS);
  localparam int unsigned FRAME_BITS = NUM_SUB * SUB_BITS;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS);

  logic              armed;
  logic              port_en;
  rate_e             rate;
  logic [SLOT_W-1:0] slot;
  logic              frame_start;
  logic              bit_end;
  logic              synced;
  logic [CNT_W-1:0]  bit_cnt;
  sub_word_t         tx_word;
  sub_word_t         rx_word;

  assign tx_word = '{b1: tx_b1_i, b2: tx_b2_i, mon: tx_mon_i, ci: tx_ci_i, hs: tx_hs_i};
  assign rx_b1_o  = rx_word.b1;
  assign rx_b2_o  = rx_word.b2;
  assign rx_mon_o = rx_word.mon;
  assign rx_ci_o  = rx_word.ci;
  assign rx_hs_o  = rx_word.hs;

  gci_strap_latch #(.SLOT_W(SLOT_W)) u_strap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (strap_mode_i),
    .rate_i (strap_rate_i),
    .sel_i  (strap_sel_i),
    .armed_o(armed),
    .en_o   (port_en),
    .rate_o (rate),
    .slot_o (slot)
  );

  gci_frame_timer #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .armed_i      (armed),
    .en_i         (port_en),
    .rate_i       (rate),
    .fsync_i      (fsync_i),
    .frame_start_o(frame_start),
    .bit_end_o    (bit_end),
    .synced_o     (synced),
    .bit_o        (bit_cnt)
  );

  gci_slot_shifter #(
    .SLOT_W    (SLOT_W),
    .SUB_BITS  (SUB_BITS),
    .POS_W     (POS_W),
    .FRAME_BITS(FRAME_BITS),
    .CNT_W     (CNT_W)
  ) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .synced_i     (synced),
    .frame_start_i(frame_start),
    .bit_end_i    (bit_end),
    .bit_i        (bit_cnt),
    .slot_i       (slot),
    .tx_word_i    (tx_word),
    .drx_i        (drx_i),
    .dtx_o        (dtx_o),
    .oe_o         (dtx_oe_o),
    .rx_word_o    (rx_word),
    .rx_valid_o   (rx_valid_o)
  );
endmodule

// File: rtl/gci_port_chk.sv
module gci_port_chk #(
  parameter int unsigned SLOT_W = 3,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              armed_i,
  input logic              en_i,
  input logic              rate_i,
  input logic [SLOT_W-1:0] slot_i,
  input logic              frame_start_i,
  input logic [CNT_W-1:0]  bit_i,
  input logic              oe_i,
  input logic              valid_i
);
  // R2
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i |=> $stable(slot_i) && $stable(en_i) && $stable(rate_i));

  // R3
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && !en_i) |-> (!oe_i && !valid_i));

  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  // R7
  valid_after_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(oe_i));

  // R9
  resync_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (bit_i == '0));
endmodule

bind gci_slot_port gci_port_chk #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .armed_i      (armed),
  .en_i         (port_en),
  .rate_i       (rate),
  .slot_i       (slot),
  .frame_start_i(frame_start),
  .bit_i        (bit_cnt),
  .oe_i         (dtx_oe_o),
  .valid_i      (rx_valid_o)
);

// File: tb/sim_gci_slot_port.sv
module sim_gci_slot_port;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       strap_mode = 1'b0;
  logic       strap_rate = 1'b0;
  logic [2:0] strap_sel = 3'b111;
  logic       fsync = 1'b0;
  logic       drx = 1'b1;
  logic       dtx, dtx_oe;
  logic [7:0] tx_b1 = '0, tx_b2 = '0, tx_mon = '0;
  logic [5:0] tx_ci = '0;
  logic [1:0] tx_hs = '0;
  logic [7:0] rx_b1, rx_b2, rx_mon;
  logic [5:0] rx_ci;
  logic [1:0] rx_hs;
  logic       rx_valid;

  int checks = 0;
  int fails  = 0;
  int vcount = 0;
  logic [31:0] snap = '0;
  bit done = 1'b0;

  always #2ns clk = ~clk;

  gci_slot_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .strap_mode_i(strap_mode), .strap_rate_i(strap_rate),
    .strap_sel_i(strap_sel), .fsync_i(fsync), .drx_i(drx), .dtx_o(dtx), .dtx_oe_o(dtx_oe),
    .tx_b1_i(tx_b1), .tx_b2_i(tx_b2), .tx_mon_i(tx_mon), .tx_ci_i(tx_ci), .tx_hs_i(tx_hs),
    .rx_b1_o(rx_b1), .rx_b2_o(rx_b2), .rx_mon_o(rx_mon), .rx_ci_o(rx_ci), .rx_hs_o(rx_hs),
    .rx_valid_o(rx_valid)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      vcount = vcount + 1;
      snap   = {rx_b1, rx_b2, rx_mon, rx_ci, rx_hs};
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit mode, input bit rate, input int slot);
    rst_ni = 1'b0;
    fsync = 1'b0;
    drx = 1'b1;
    strap_mode = mode;
    strap_rate = rate;
    strap_sel = ~3'(slot);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle(input int n);
    fsync = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // drives one frame from the current negedge; checks dtx/oe every cycle
  task automatic run_frame(input int nbits, input int slot, input bit x2, input bit en,
                           input logic [31:0] txw, input logic [31:0] rxw, input string req);
    int k = x2 ? 2 : 1;
    {tx_b1, tx_b2, tx_mon, tx_ci, tx_hs} = txw;
    fsync = 1'b1;
    for (int c = 0; c < nbits * k; c++) begin
      int  b;
      int  ph;
      bit  own;
      bit  exp_d;
      bit  val;
      @(negedge clk);
      fsync = 1'b0;
      b   = c / k;
      ph  = c % k;
      own = en && ((b / 32) == slot);
      exp_d = own ? txw[31 - (b % 32)] : 1'b1;
      chk(dtx_oe == own, own ? "R5" : "R6", $sformatf("oe bit %0d", b), dtx_oe, own);
      chk(dtx == exp_d, own ? (x2 ? "R8" : "R5") : "R6", $sformatf("dtx bit %0d", b), dtx, exp_d);
      val = own ? rxw[31 - (b % 32)] : b[0];
      drx = (x2 && ph == 0) ? ~val : val;
    end
    chk(1'b1, req, "frame done", 0, 0);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    strap_mode = 1'b0;
    strap_sel = 3'b111;
    repeat (2) @(negedge clk);
    chk(dtx_oe == 1'b0, "R1", "oe in reset", dtx_oe, 0);
    chk(dtx == 1'b1, "R1", "dtx in reset", dtx, 1);
    chk(rx_valid == 1'b0, "R1", "valid in reset", rx_valid, 0);
    chk({rx_b1, rx_b2, rx_mon, rx_ci, rx_hs} == '0, "R1", "rx in reset",
        {rx_b1, rx_b2, rx_mon, rx_ci, rx_hs}, 0);
    do_reset(1'b0, 1'b0, 0);
    fsync = 1'b0;
    repeat (40) @(negedge clk);
    chk(dtx_oe == 1'b0, "R1", "oe before sync", dtx_oe, 0);
    chk(dtx == 1'b1, "R1", "dtx before sync", dtx, 1);
    chk(vcount == 0, "R1", "valid before sync", vcount, 0);
  endtask

  task automatic t_slot(input int slot, input logic [31:0] txw, input logic [31:0] rxw);
    int v0;
    do_reset(1'b0, 1'b0, slot);
    v0 = vcount;
    run_frame(256, slot, 1'b0, 1'b1, txw, rxw, "R4");
    idle(3);
    chk(vcount == v0 + 1, "R7", $sformatf("valid count slot %0d", slot), vcount - v0, 1);
    chk(snap == rxw, "R7", $sformatf("rx word slot %0d", slot), snap, rxw);
  endtask

  task automatic t_rate2x;
    int v0;
    do_reset(1'b0, 1'b1, 5);
    v0 = vcount;
    run_frame(256, 5, 1'b1, 1'b1, 32'hC3A5_5A3D, 32'h9E37_79B9, "R8");
    idle(3);
    chk(vcount == v0 + 1, "R8", "valid count 2x", vcount - v0, 1);
    chk(snap == 32'h9E37_79B9, "R8", "rx word 2x", snap, 32'h9E37_79B9);
  endtask

  task automatic t_disabled;
    int v0;
    do_reset(1'b1, 1'b0, 0);
    v0 = vcount;
    run_frame(256, 0, 1'b0, 1'b0, 32'h0F0F_0F0F, 32'h1234_5678, "R3");
    idle(3);
    chk(vcount == v0, "R3", "valid while disabled", vcount - v0, 0);
  endtask

  task automatic t_resync;
    int v0;
    do_reset(1'b0, 1'b0, 1);
    v0 = vcount;
    run_frame(45, 1, 1'b0, 1'b1, 32'hAAAA_5555, 32'hFFFF_0000, "R9");
    chk(vcount == v0, "R9", "no valid for cut subframe", vcount - v0, 0);
    run_frame(256, 1, 1'b0, 1'b1, 32'h1357_9BDF, 32'h2468_ACE0, "R9");
    idle(3);
    chk(vcount == v0 + 1, "R9", "valid after resync", vcount - v0, 1);
    chk(snap == 32'h2468_ACE0, "R9", "rx word after resync", snap, 32'h2468_ACE0);
  endtask

  task automatic t_strap_hold;
    int v0;
    do_reset(1'b0, 1'b0, 2);
    strap_sel = 3'b000;
    strap_rate = 1'b1;
    strap_mode = 1'b1;
    v0 = vcount;
    run_frame(256, 2, 1'b0, 1'b1, 32'h5A5A_F00F, 32'h0BAD_CAFE, "R2");
    idle(3);
    chk(vcount == v0 + 1, "R2", "valid count after strap change", vcount - v0, 1);
    chk(snap == 32'h0BAD_CAFE, "R2", "rx word after strap change", snap, 32'h0BAD_CAFE);
  endtask

  initial begin
    t_reset();
    t_slot(0, 32'hDEAD_BEEF, 32'h8123_4567);
    t_slot(3, 32'h0123_4567, 32'hFEDC_BA98);
    t_slot(7, 32'hA5C3_3C5B, 32'h7E81_18E6);
    t_rate2x();
    t_disabled();
    t_resync();
    t_strap_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400us;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule